// File: doc/BRIEF.md
# Shared Interrupt Line Merger

This block gathers level-sensitive interrupt requests from a set of devices and drives a small number of shared interrupt lines. Each device has four request pins, numbered 0 to 3. A fixed routing rule assigns every device pin to one line.

For each line the block keeps a count of the pins currently requesting it. The line is driven high whenever that count is nonzero.

The count does not OR the inputs again on every cycle. Instead, the block remembers the last level it saw on each pin. It adds the signed difference between the new level and the remembered level to the count of the routed line. A pin that holds its level therefore adds nothing. Pins that change in the same cycle are summed into one net change per line.

Device `d` sits in slot `SLOT_BASE + d`. Its 8-bit device/function number is that slot shifted left by three, with function 0. The slot used for routing is read back from the upper five bits of that number.

Top module: `irq_line_merge`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, every line output is 0. All remembered pin levels and all counts are cleared by reset.
- R2: Pin `p` of device `d` is bit `4*d + p` of `pin_level`. It routes to line `(SLOT_BASE + d + p) mod NUM_LINES`. With the defaults, device 0 pin 0 drives line 1 and device 3 pin 3 drives line 3.
- R3: A line output is 1 exactly when at least one pin routed to it was high at the previous clock edge. A line shared by several high pins stays high until the last of them falls.
- R4: A pin held at the same level adds no further change. A pin held high for many cycles and then released clears its line on the edge after the release.
- R5: When one pin routed to a line falls in the same cycle that another pin routed to that line rises, the changes cancel and the line stays high.
- R6: With all pins high, every line is high. The count for each line is wide enough for all device pins, so it cannot overflow. Releasing all pins clears all lines.
- R7: A line output changes exactly one clock edge after the input change that causes it, and not before.
- R8: After reset, the remembered levels start at 0. A pin that is high when reset is released is treated as a rising change on the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_level | input | NUM_DEV*4 | Request level of each device pin, bit 4*d+p |
| line_out | output | NUM_LINES | Merged shared interrupt lines |

## Verification
Two functions can land on the same line in the same cycle: the counting of a rising pin and the counting of a falling pin. The bench provokes this by moving a request from one pin to another pin routed to the same line within a single input change. It judges the result by requiring that the line stays high with no dropped cycle. A single vector that releases one pin while a second one stays high also exercises the shared count on one line.

// File: rtl/irqm_pkg.sv
// Package: shared constants and the routing rule of the interrupt line merger.
// Assumes slot numbers fit in five bits.
package irqm_pkg;

    localparam int PINS_PER_DEV = 4;

    // Builds the 8-bit device/function number of a slot (function 0).
    function automatic logic [7:0] devfn_of_slot(input int slot);
        return 8'((slot % 32) << 3);
    endfunction

    // Routing rule: slot from the upper five bits plus pin, modulo the line count.
    function automatic int route_line(input logic [7:0] devfn, input int pin, input int nlines);
        return (int'(devfn[7:3]) + pin) % nlines;
    endfunction

endpackage

// File: rtl/irqm_pin_tracker.sv
// Module: remembers the last seen level of every device pin and reports
// per-pin rising (+1) and falling (-1) changes against the remembered level.
// Assumes pin levels are already synchronous to clk.
module irqm_pin_tracker #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] level,
    output logic [NUM_PINS-1:0] up,
    output logic [NUM_PINS-1:0] down
);

    logic [NUM_PINS-1:0] seen_q;

    // Signed change of each pin: new level minus remembered level.
    always_comb begin
        up   = level & ~seen_q;
        down = ~level & seen_q;
    end

    // Update the remembered level only for pins whose change is nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (up[i] || down[i]) begin
                    seen_q[i] <= level[i];
                end
            end
        end
    end

endmodule

// File: rtl/irqm_line_accum.sv
// Module: one shared line. Sums the signed changes of every pin routed to
// LINE_IDX, keeps the count of asserting pins, and registers count != 0.
// Assumes CNT_W can hold the total number of pins.
module irqm_line_accum #(
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4,
    parameter int SLOT_BASE = 1,
    parameter int LINE_IDX  = 0,
    parameter int CNT_W     = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_DEV*irqm_pkg::PINS_PER_DEV-1:0] up,
    input  logic [NUM_DEV*irqm_pkg::PINS_PER_DEV-1:0] down,
    output logic                                  line
);
    import irqm_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_up;
    logic [CNT_W-1:0] n_down;
    logic [CNT_W-1:0] cnt_next;

    // Count the rises and falls routed to this line in this cycle.
    always_comb begin
        n_up   = '0;
        n_down = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int p = 0; p < PINS_PER_DEV; p++) begin
                if (route_line(devfn_of_slot(SLOT_BASE + d), p, NUM_LINES) == LINE_IDX) begin
                    if (up[d*PINS_PER_DEV + p])   n_up   = n_up   + CNT_W'(1);
                    if (down[d*PINS_PER_DEV + p]) n_down = n_down + CNT_W'(1);
                end
            end
        end
        cnt_next = cnt_q + n_up - n_down;
    end

    // Hold the asserting-pin count and the registered line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            line  <= 1'b0;
        end else begin
            cnt_q <= cnt_next;
            line  <= (cnt_next != '0);
        end
    end

endmodule

// File: rtl/irq_line_merge.sv
// Module: top of the shared interrupt line merger. One pin tracker feeds
// one accumulator per line. Lines update one edge after a pin change.
// Assumes SLOT_BASE + NUM_DEV - 1 < 32.
module irq_line_merge #(
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4,
    parameter int SLOT_BASE = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_DEV*4-1:0]   pin_level,
    output logic [NUM_LINES-1:0]   line_out
);
    localparam int NUM_PINS = NUM_DEV * irqm_pkg::PINS_PER_DEV;
    localparam int CNT_W    = $clog2(NUM_PINS + 1);

    logic [NUM_PINS-1:0] pin_up;
    logic [NUM_PINS-1:0] pin_down;

    irqm_pin_tracker #(.NUM_PINS(NUM_PINS)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pin_level),
        .up    (pin_up),
        .down  (pin_down)
    );

    // One accumulator per shared line.
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        irqm_line_accum #(
            .NUM_DEV   (NUM_DEV),
            .NUM_LINES (NUM_LINES),
            .SLOT_BASE (SLOT_BASE),
            .LINE_IDX  (l),
            .CNT_W     (CNT_W)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .up    (pin_up),
            .down  (pin_down),
            .line  (line_out[l])
        );
    end

endmodule

// File: rtl/irqm_checker.sv
// Checker: port-level properties of the interrupt line merger, bound to the top.
module irqm_checker #(
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4,
    parameter int SLOT_BASE = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_DEV*4-1:0]  pin_level,
    input logic [NUM_LINES-1:0]  line_out
);

    // Lines that must be high for a given set of pin levels.
    function automatic logic [NUM_LINES-1:0] lines_of(input logic [NUM_DEV*4-1:0] lv);
        logic [NUM_LINES-1:0] r;
        r = '0;
        for (int d = 0; d < NUM_DEV; d++)
            for (int p = 0; p < 4; p++)
                if (lv[d*4 + p]) r[(SLOT_BASE + d + p) % NUM_LINES] = 1'b1;
        return r;
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (line_out == '0));

    assert_line_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (line_out == lines_of($past(pin_level))));

    assert_hold_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(pin_level)) |=> $stable(line_out));

    assert_all_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_level) |=> (&line_out));

endmodule

bind irq_line_merge irqm_checker #(
    .NUM_DEV   (NUM_DEV),
    .NUM_LINES (NUM_LINES),
    .SLOT_BASE (SLOT_BASE)
) u_irqm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .line_out  (line_out)
);

// File: tb/irq_line_merge_bench.sv
module irq_line_merge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_level = '0;
    logic [3:0]  line_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_line_merge u_irq_line_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .line_out  (line_out)
    );

    // Stimulus {pins, expected lines}; routing (1+d+p)%4, bit 4*d+p.
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {16'h0001, 4'b0010},  // R2 d0p0 -> line1
        {16'h0001, 4'b0010},  // R4 hold
        {16'h0003, 4'b0110},  // R2 d0p1 -> line2
        {16'h0010, 4'b0100},  // R2 d1p0 -> line2
        {16'h0012, 4'b0100},  // R3 two sources on line2
        {16'h0002, 4'b0100},  // R3 one released, line2 held
        {16'h0010, 4'b0100},  // R5 swap on line2 in one cycle
        {16'h8000, 4'b1000},  // R2 d3p3 -> line3
        {16'h1248, 4'b0001},  // R2 four devices on line0
        {16'hFFFF, 4'b1111},  // R6 all high
        {16'hFFFF, 4'b1111},  // R6 hold all high
        {16'h0000, 4'b0000}   // R6 all released
    };

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (line_out !== exp) begin
            fails++;
            $display("FAIL %s: line_out=%b expected=%b", req, line_out, exp);
        end
    endtask

    task automatic apply(input logic [15:0] v);
        @(negedge clk);
        pin_level = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog: line_out=%b expected=done", line_out);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][19:4]);
            check($sformatf("R3 vec%0d", i), VEC[i][3:0]);
        end

        // R7: no change before the edge, change right after it.
        @(negedge clk);
        pin_level = 16'h0100;  // d2p0 -> line3
        #1;
        check("R7", 4'b0000);
        @(posedge clk);
        #1;
        check("R7", 4'b1000);

        // R4: long hold then release clears at the next edge.
        apply(16'h0001);
        repeat (5) @(posedge clk);
        #1;
        check("R4", 4'b0010);
        apply(16'h0000);
        check("R4", 4'b0000);

        // R1/R8: reset while pins high, then release with pins still high.
        apply(16'h0021);  // lines 1 and 3
        check("R3", 4'b1010);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R8", 4'b1010);
        apply(16'h0000);
        check("R8", 4'b0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule